// File: doc/BRIEF.md
# Parity-Interleaved Two-Byte Memory Controller

This block sits between a simple request/ready user port and a non-volatile memory array that has been split into two banks by byte-address parity: every even byte address lives in one bank and every odd byte address in the other. Because of this split, any two neighbouring bytes sit in different banks, so each transaction moves a full 16-bit word in one bank access, whether the start address is even or odd.

A request carries an 8-bit byte address, a read/write flag and, for writes, 16 bits of data. The low data byte belongs to the start address and the high byte to the address after it. Address bit 0 picks the bank that holds the first byte, and bits 7:1 are the row. When the start is odd, the following byte falls into the next row of the even bank. A dedicated address-update cycle computes that row, and the row wraps around the top of the array. This cycle removes the increment from the path that feeds the bank enables.

Writes are checked by a verify step per bank. A bank that fails verification is written again, and only that bank. After four failed attempts the controller gives up and flags an error when it reports completion.

Top module: `duo_bank_ctrl`

## Requirements
- R1: After reset, ready is 1, done and error are 0, and neither bank enable is asserted.
- R2: A write from an even address A stores data[7:0] in the even bank and data[15:8] in the odd bank, both at row A[7:1].
- R3: A write from an odd address A stores data[7:0] in the odd bank at row A[7:1], and data[15:8] in the even bank at row (A[7:1]+1) mod 128. Start address 0xFF therefore wraps to even row 0.
- R4: A read returns, in the cycle in which done is high, rd_data[7:0] from the start address and rd_data[15:8] from the address after it, with the same bank and row mapping as R2 and R3.
- R5: In the cycle after a request is accepted, neither bank is enabled. Whenever both banks are enabled together, the even row equals the odd row or exceeds it by one (mod 128).
- R6: Every bank write cycle (enable and write high) is followed directly by a verify cycle on that bank (enable high, write low). done rises only after every bank has passed its verify or R8 applies.
- R7: A bank that fails its verify is written again, while a bank that has passed is not written again in the same transaction.
- R8: A bank is written at most 4 times per transaction. If the fourth verify still fails, done is raised with error high. error is low in every other cycle.
- R9: ready goes low in the cycle after acceptance and stays low through the single cycle in which done is high. ready is high again in the next cycle.
- R10: A request presented while ready is low is ignored and leaves both banks untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken when ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Start byte address |
| req_wdata | input | 16 | Write data; [7:0] for the start address |
| ready | output | 1 | Controller idle and accepting |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Write verify exhausted, valid with done |
| rd_data | output | 16 | Read result, valid with done |
| ev_en | output | 1 | Even bank enable |
| ev_we | output | 1 | Even bank write (with enable) |
| ev_row | output | 7 | Even bank row |
| ev_wdata | output | 8 | Even bank write byte |
| ev_rdata | input | 8 | Even bank read byte, one cycle after enable |
| ev_vok | input | 1 | Even bank verify pass, sampled in a verify cycle |
| od_en | output | 1 | Odd bank enable |
| od_we | output | 1 | Odd bank write (with enable) |
| od_row | output | 7 | Odd bank row |
| od_wdata | output | 8 | Odd bank write byte |
| od_rdata | input | 8 | Odd bank read byte, one cycle after enable |
| od_vok | input | 1 | Odd bank verify pass, sampled in a verify cycle |

## Verification
The hardest situations to reach are the uneven retry, where one bank passes at once and the other fails several times, and the case where retries run out. A correct array never produces either. The bench's behavioural banks hold a per-bank count of writes to corrupt. A corrupted write stores the inverted byte, and the verify input then compares the stored byte against the presented one. Loading that count before a transaction yields any mix of pass and fail per bank. The bench counts write strobes at the bank ports to confirm that only the failing bank repeats and that the count stops at four.

// File: rtl/dbc_pkg.sv
// Shared types for the parity-interleaved two-byte controller.
// Assumes: single clock domain; no other package defines these names.
package dbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WRITE,
        ST_VERIFY,
        ST_READ,
        ST_RCAP,
        ST_DONE
    } dbc_state_t;

    localparam int LANE_EVEN = 0;
    localparam int LANE_ODD  = 1;

endpackage

// File: rtl/dbc_row_predecode.sv
// Row pre-decoder: registers the row for each parity bank during the
// address-update cycle, so the increment for odd starts is off the
// enable path. Assumes load is a one-cycle strobe and inputs are stable.
module dbc_row_predecode #(
    parameter int ROW_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ROW_W-1:0] start_row,
    input  logic             odd_start,
    output logic [ROW_W-1:0] ev_row,
    output logic [ROW_W-1:0] od_row,
    output logic             swap
);

    // Capture both bank rows and the lane swap flag on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_row <= '0;
            od_row <= '0;
            swap   <= 1'b0;
        end else if (load) begin
            od_row <= start_row;
            ev_row <= odd_start ? start_row + ROW_W'(1) : start_row;
            swap   <= odd_start;
        end
    end

endmodule

// File: rtl/dbc_byte_steer.sv
// Byte steering between the 16-bit user word and the two bank lanes.
// Lane 0 of the word is the start address byte. When swap is set the
// start byte sits in the odd bank. Purely combinational.
module dbc_byte_steer #(
    parameter int BYTE_W = 8
) (
    input  logic              swap,
    input  logic [2*BYTE_W-1:0] word_in,
    input  logic [BYTE_W-1:0] ev_rbyte,
    input  logic [BYTE_W-1:0] od_rbyte,
    output logic [BYTE_W-1:0] ev_wbyte,
    output logic [BYTE_W-1:0] od_wbyte,
    output logic [2*BYTE_W-1:0] word_out
);

    logic [BYTE_W-1:0] bank_r [2];
    logic [BYTE_W-1:0] bank_w [2];

    assign bank_r[dbc_pkg::LANE_EVEN] = ev_rbyte;
    assign bank_r[dbc_pkg::LANE_ODD]  = od_rbyte;
    assign ev_wbyte = bank_w[dbc_pkg::LANE_EVEN];
    assign od_wbyte = bank_w[dbc_pkg::LANE_ODD];

    // One mux pair per word lane: lane i maps to bank i xor swap.
    for (genvar i = 0; i < 2; i++) begin : g_lane
        always_comb begin
            bank_w[i] = swap ? word_in[(1-i)*BYTE_W +: BYTE_W]
                             : word_in[i*BYTE_W +: BYTE_W];
            word_out[i*BYTE_W +: BYTE_W] = swap ? bank_r[1-i] : bank_r[i];
        end
    end

endmodule

// File: rtl/dbc_verify_track.sv
// Per-bank write/verify bookkeeping: a pending mask of banks that still
// need a good write and a shared attempt counter. Assumes start precedes
// the first write pulse and check is asserted only in verify cycles.
module dbc_verify_track #(
    parameter int MAX_TRIES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       write_pulse,
    input  logic       check,
    input  logic [1:0] vok,
    output logic [1:0] pend,
    output logic       all_ok,
    output logic       exhausted
);

    localparam int TRY_W = $clog2(MAX_TRIES + 1);

    logic [TRY_W-1:0] tries;

    // Banks left pending after this verify.
    assign all_ok    = (pend & ~vok) == 2'b00;
    assign exhausted = tries >= TRY_W'(MAX_TRIES);

    // Update the pending mask and attempt count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= 2'b00;
            tries <= '0;
        end else if (start) begin
            pend  <= 2'b11;
            tries <= '0;
        end else begin
            if (write_pulse) tries <= tries + TRY_W'(1);
            if (check)       pend  <= pend & ~vok;
        end
    end

endmodule

// File: rtl/duo_bank_ctrl.sv
// Top of the parity-interleaved two-byte controller. Accepts one request
// at a time, spends one cycle computing bank rows, then reads both banks
// together or runs write/verify per bank with up to MAX_TRIES attempts.
// Assumes bank read data arrives one cycle after a read enable and the
// verify inputs are valid combinationally in the verify cycle.
module duo_bank_ctrl
    import dbc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BYTE_W    = 8,
    parameter int MAX_TRIES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*BYTE_W-1:0] req_wdata,
    output logic                ready,
    output logic                done,
    output logic                error,
    output logic [2*BYTE_W-1:0] rd_data,
    output logic                ev_en,
    output logic                ev_we,
    output logic [ADDR_W-2:0]   ev_row,
    output logic [BYTE_W-1:0]   ev_wdata,
    input  logic [BYTE_W-1:0]   ev_rdata,
    input  logic                ev_vok,
    output logic                od_en,
    output logic                od_we,
    output logic [ADDR_W-2:0]   od_row,
    output logic [BYTE_W-1:0]   od_wdata,
    input  logic [BYTE_W-1:0]   od_rdata,
    input  logic                od_vok
);

    localparam int ROW_W  = ADDR_W - 1;
    localparam int WORD_W = 2 * BYTE_W;

    dbc_state_t          state, state_nx;
    logic                op_write;
    logic [ADDR_W-1:0]   addr_q;
    logic [WORD_W-1:0]   wdata_q;
    logic [WORD_W-1:0]   rd_q;
    logic [WORD_W-1:0]   rd_steered;
    logic                err_q;
    logic                accept;
    logic                swap;
    logic [1:0]          pend;
    logic                all_ok;
    logic                exhausted;

    assign accept = (state == ST_IDLE) && req_valid;

    // Latch the request on acceptance; later requests are not seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_write <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
        end else if (accept) begin
            op_write <= req_write;
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
        end
    end

    dbc_row_predecode #(.ROW_W(ROW_W)) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state == ST_ADDR),
        .start_row (addr_q[ADDR_W-1:1]),
        .odd_start (addr_q[0]),
        .ev_row    (ev_row),
        .od_row    (od_row),
        .swap      (swap)
    );

    dbc_byte_steer #(.BYTE_W(BYTE_W)) u_steer (
        .swap     (swap),
        .word_in  (wdata_q),
        .ev_rbyte (ev_rdata),
        .od_rbyte (od_rdata),
        .ev_wbyte (ev_wdata),
        .od_wbyte (od_wdata),
        .word_out (rd_steered)
    );

    dbc_verify_track #(.MAX_TRIES(MAX_TRIES)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (state == ST_ADDR),
        .write_pulse (state == ST_WRITE),
        .check       (state == ST_VERIFY),
        .vok         ({od_vok, ev_vok}),
        .pend        (pend),
        .all_ok      (all_ok),
        .exhausted   (exhausted)
    );

    // Next-state selection for the transaction sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = ST_ADDR;
            ST_ADDR:   state_nx = op_write ? ST_WRITE : ST_READ;
            ST_WRITE:  state_nx = ST_VERIFY;
            ST_VERIFY: state_nx = (all_ok || exhausted) ? ST_DONE : ST_WRITE;
            ST_READ:   state_nx = ST_RCAP;
            ST_RCAP:   state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Error flag: cleared on acceptance, set when verify runs out of tries.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          err_q <= 1'b0;
        else if (accept)                                     err_q <= 1'b0;
        else if (state == ST_VERIFY && !all_ok && exhausted) err_q <= 1'b1;
    end

    // Capture steered read data one cycle after the bank read.
    always_ff @(posedge clk) begin
        if (!rst_n)                rd_q <= '0;
        else if (state == ST_RCAP) rd_q <= rd_steered;
    end

    // Bank strobes: pending banks during write/verify, both during read.
    always_comb begin
        ev_en = (state == ST_READ) ||
                ((state == ST_WRITE || state == ST_VERIFY) && pend[LANE_EVEN]);
        od_en = (state == ST_READ) ||
                ((state == ST_WRITE || state == ST_VERIFY) && pend[LANE_ODD]);
        ev_we = (state == ST_WRITE) && pend[LANE_EVEN];
        od_we = (state == ST_WRITE) && pend[LANE_ODD];
    end

    assign ready   = (state == ST_IDLE);
    assign done    = (state == ST_DONE);
    assign error   = done && err_q;
    assign rd_data = rd_q;

endmodule

// File: rtl/dbc_checker.sv
// Protocol checker for duo_bank_ctrl, attached by bind. Observes ports
// only; counts write strobes per bank within a transaction.
module dbc_checker #(
    parameter int ROW_W     = 7,
    parameter int MAX_TRIES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready,
    input logic             done,
    input logic             error,
    input logic             ev_en,
    input logic             ev_we,
    input logic [ROW_W-1:0] ev_row,
    input logic             od_en,
    input logic             od_we,
    input logic [ROW_W-1:0] od_row
);

    localparam int CW = $clog2(MAX_TRIES + 2) + 1;

    logic [CW-1:0] ev_wr, od_wr;

    // Count write strobes per bank since the controller was last idle.
    always_ff @(posedge clk) begin
        if (!rst_n || ready) begin
            ev_wr <= '0;
            od_wr <= '0;
        end else begin
            if (ev_en && ev_we) ev_wr <= ev_wr + CW'(1);
            if (od_en && od_we) od_wr <= od_wr + CW'(1);
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!ev_en && !od_en && !done));

    assert_row_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_en && od_en) |-> (ev_row == od_row || ev_row == od_row + ROW_W'(1)));

    assert_no_enable_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> (!ev_en && !od_en));

    assert_ev_verify_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_en && ev_we) |=> (ev_en && !ev_we));

    assert_od_verify_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (od_en && od_we) |=> (od_en && !od_we));

    assert_write_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wr <= CW'(MAX_TRIES)) && (od_wr <= CW'(MAX_TRIES)));

    assert_error_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && ready));

    assert_busy_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ready);

endmodule

bind duo_bank_ctrl dbc_checker #(.ROW_W(ADDR_W-1), .MAX_TRIES(MAX_TRIES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ready  (ready),
    .done   (done),
    .error  (error),
    .ev_en  (ev_en),
    .ev_we  (ev_we),
    .ev_row (ev_row),
    .od_en  (od_en),
    .od_we  (od_we),
    .od_row (od_row)
);

// File: tb/duo_bank_ctrl_test.sv
// Directed bench for duo_bank_ctrl with behavioural parity banks.
module duo_bank_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        ready, done, error;
    logic [15:0] rd_data;
    logic        ev_en, ev_we, od_en, od_we;
    logic [6:0]  ev_row, od_row;
    logic [7:0]  ev_wdata, od_wdata;
    logic [7:0]  ev_rdata, od_rdata;
    logic        ev_vok, od_vok;

    logic [7:0]  mem_ev [128];
    logic [7:0]  mem_od [128];
    int          fail_ev = 0, fail_od = 0;
    int          ev_wcnt = 0, od_wcnt = 0;
    int          compared = 0, mismatched = 0;
    int          cyc = 0;
    logic        got_err;
    logic [15:0] got_rd;

    always #2 clk = ~clk;

    duo_bank_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
        .error(error), .rd_data(rd_data),
        .ev_en(ev_en), .ev_we(ev_we), .ev_row(ev_row), .ev_wdata(ev_wdata),
        .ev_rdata(ev_rdata), .ev_vok(ev_vok),
        .od_en(od_en), .od_we(od_we), .od_row(od_row), .od_wdata(od_wdata),
        .od_rdata(od_rdata), .od_vok(od_vok)
    );

    // Behavioural banks: corrupted writes store the inverted byte.
    always @(posedge clk) begin
        if (ev_en && ev_we) begin
            mem_ev[ev_row] <= (fail_ev > 0) ? ~ev_wdata : ev_wdata;
            if (fail_ev > 0) fail_ev <= fail_ev - 1;
            ev_wcnt <= ev_wcnt + 1;
        end
        if (od_en && od_we) begin
            mem_od[od_row] <= (fail_od > 0) ? ~od_wdata : od_wdata;
            if (fail_od > 0) fail_od <= fail_od - 1;
            od_wcnt <= od_wcnt + 1;
        end
        if (ev_en && !ev_we) ev_rdata <= mem_ev[ev_row];
        if (od_en && !od_we) od_rdata <= mem_od[od_row];
    end

    assign ev_vok = ev_en && !ev_we && (mem_ev[ev_row] == ev_wdata);
    assign od_vok = od_en && !od_we && (mem_od[od_row] == od_wdata);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // Present one request, check the address-update cycle, wait for done.
    task automatic run_req(input logic wr, input logic [7:0] a, input logic [15:0] d);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 ready low after accept", {31'b0, ready}, 32'd0);
        chk("R5 no enable in row cycle", {30'b0, ev_en, od_en}, 32'd0);
        n = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk("R9 done seen", {31'b0, done}, 32'd1);
        chk("R9 ready low with done", {31'b0, ready}, 32'd0);
        got_err = error;
        got_rd  = rd_data;
        @(negedge clk);
        chk("R9 done single cycle", {31'b0, done}, 32'd0);
        chk("R9 ready back", {31'b0, ready}, 32'd1);
        chk("R8 error only with done", {31'b0, error}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 ready", {31'b0, ready}, 32'd1);
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 error", {31'b0, error}, 32'd0);
        chk("R1 enables", {30'b0, ev_en, od_en}, 32'd0);
    endtask

    task automatic t_even();
        ev_wcnt = 0; od_wcnt = 0;
        run_req(1'b1, 8'h10, 16'hBEEF);
        chk("R2 even bank byte", {24'b0, mem_ev[8]}, 32'hEF);
        chk("R2 odd bank byte", {24'b0, mem_od[8]}, 32'hBE);
        chk("R6 one write each", ev_wcnt * 16 + od_wcnt, 32'h11);
        chk("R8 no error", {31'b0, got_err}, 32'd0);
        run_req(1'b0, 8'h10, 16'h0);
        chk("R4 even read order", {16'b0, got_rd}, 32'hBEEF);
    endtask

    task automatic t_odd();
        run_req(1'b1, 8'h21, 16'h1234);
        chk("R3 odd bank row r", {24'b0, mem_od[7'h10]}, 32'h34);
        chk("R3 even bank row r+1", {24'b0, mem_ev[7'h11]}, 32'h12);
        run_req(1'b0, 8'h21, 16'h0);
        chk("R4 odd read order", {16'b0, got_rd}, 32'h1234);
    endtask

    task automatic t_wrap();
        run_req(1'b1, 8'hFF, 16'hA55A);
        chk("R3 wrap odd row 127", {24'b0, mem_od[127]}, 32'h5A);
        chk("R3 wrap even row 0", {24'b0, mem_ev[0]}, 32'hA5);
        run_req(1'b0, 8'hFF, 16'h0);
        chk("R4 wrap read order", {16'b0, got_rd}, 32'hA55A);
    endtask

    task automatic t_retry();
        fail_ev = 2; ev_wcnt = 0; od_wcnt = 0;
        run_req(1'b1, 8'h40, 16'hC3D2);
        chk("R7 failing bank rewritten", ev_wcnt, 32'd3);
        chk("R7 passing bank once", od_wcnt, 32'd1);
        chk("R6 data after retry", {mem_od[7'h20], mem_ev[7'h20]}, 32'hC3D2);
        chk("R8 no error after recovery", {31'b0, got_err}, 32'd0);
    endtask

    task automatic t_exhaust();
        fail_od = 9; ev_wcnt = 0; od_wcnt = 0;
        run_req(1'b1, 8'h62, 16'h7788);
        chk("R8 write attempts capped", od_wcnt, 32'd4);
        chk("R8 good bank once", ev_wcnt, 32'd1);
        chk("R8 error with done", {31'b0, got_err}, 32'd1);
        fail_od = 0;
        run_req(1'b1, 8'h62, 16'h7788);
        chk("R8 error clears", {31'b0, got_err}, 32'd0);
    endtask

    task automatic t_busy();
        int n;
        fail_ev = 3;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h50; req_wdata = 16'h9911;
        @(negedge clk);
        req_addr = 8'h70; req_wdata = 16'hDEAD;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        chk("R10 ignored even row", {24'b0, mem_ev[7'h38]}, 32'h00);
        chk("R10 ignored odd row", {24'b0, mem_od[7'h38]}, 32'h00);
        chk("R10 first request stored", {mem_od[7'h28], mem_ev[7'h28]}, 32'h9911);
        chk("R10 idle after", {31'b0, ready}, 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            mem_ev[i] = 8'h00;
            mem_od[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_even();
        t_odd();
        t_wrap();
        t_retry();
        t_exhaust();
        t_busy();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule